// File: doc/BRIEF.md
# Stochastic 2x2 Diagonal Edge Detector

This block scores one 2x2 window of pixel intensities for edge strength using stochastic arithmetic. Each of the four pixels becomes a bitstream. A stream bit is 1 when the pixel exceeds a pseudo-random value. All four pixels are compared against the same random value in the same cycle, so their ones overlap as much as possible. Because of that overlap, one XOR gate per diagonal gives the absolute difference of the two diagonal pixels. A 2-to-1 multiplexer, driven by an independent random select bit of probability one half, merges the two differences into half their sum.

An up-counter counts the ones on the merged stream. After a full run of 256 cycles it holds the weighted-binary edge score, about (|tl - br| + |tr - bl|) / 2. Reduced-precision estimates are published after 4 and 32 cycles, scaled to the same 256 full-scale range, so a caller that needs only a coarse edge map can act on it early. A one-cycle start pulse launches a run.

Top module: `sc_edge_window`

## Requirements
- R1: While reset is asserted, and after it, busy, done, snap_valid and count are all 0. Reset is asserted asynchronously and released through a two-stage synchronizer.
- R2: A pixel's stream bit is 1 when the pixel value is strictly greater than the shared random value. The top-left/bottom-right pair and the top-right/bottom-left pair are each combined by XOR. A window whose diagonal pairs are equal therefore ends the run with count 0.
- R3: The merged bit takes the top-right/bottom-left difference when the select bit is 1 and the top-left/bottom-right difference when it is 0. The select bit is bit 7 of the select generator's current state.
- R4: The random value comes from an 8-bit generator that shifts left and takes feedback s7^s5^s4^s3 into bit 0. The select generator uses feedback s7^s5^s4^s2. On start they are loaded with 0x01 and 0xA5 respectively. Each run cycle uses the current states, and both generators advance after that cycle.
- R5: Neither generator state is ever zero.
- R6: In each run cycle the count grows by exactly the merged bit, so it never exceeds the number of cycles run.
- R7: After the start edge, busy stays high for exactly 256 accumulation edges. It then falls, and done rises in the same cycle.
- R8: While done is high and no start arrives, count stays frozen and done stays high.
- R9: snap_valid pulses for one cycle after the 4th, 32nd and 256th accumulation, with snap_tag 0, 1 and 2. snap_value is count×64, count×8 and count respectively.
- R10: A start during a run abandons it, and the new run matches a fresh run bit for bit.
- R11: For tl=255, br=0, tr=255, bl=0 the final count is 255. Both differences are 1 in every cycle except the one cycle in which the random value is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts or restarts a run |
| pix_tl | input | 8 | Top-left intensity |
| pix_tr | input | 8 | Top-right intensity |
| pix_bl | input | 8 | Bottom-left intensity |
| pix_br | input | 8 | Bottom-right intensity |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete, count final |
| count | output | 9 | Running count of merged ones |
| snap_valid | output | 1 | Snapshot strobe |
| snap_tag | output | 2 | Snapshot point: 0 after 4, 1 after 32, 2 after 256 cycles |
| snap_value | output | 9 | Count scaled to 256-cycle full scale |

## Verification
Several properties are checked on every cycle. The assertions require that neither random generator reaches zero. They require that the count rises by at most one per run cycle and never outruns the cycle counter, and that busy and done never overlap. They also require that a finished count stays frozen, and that a window with equal diagonals never emits a one. The bench's scenarios are the only place that shows correct values. There it compares every cycle's count, the three snapshots and the final score against a model built from the stated generator polynomials and seeds. It also covers a restart in mid-run and a reset in mid-run.

// File: rtl/sc_edge_pkg.sv
package sc_edge_pkg;
  localparam int unsigned PIX_W_DEF = 8;
  localparam logic [7:0] RND_TAPS = 8'hB8;
  localparam logic [7:0] SEL_TAPS = 8'hB4;
  localparam logic [7:0] RND_SEED = 8'h01;
  localparam logic [7:0] SEL_SEED = 8'hA5;

  typedef enum logic [1:0] {
    SNAP_EARLY = 2'd0,
    SNAP_MID   = 2'd1,
    SNAP_FINAL = 2'd2
  } snap_tag_e;
endpackage

// File: rtl/sc_lfsr.sv
module sc_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] state_nxt;
  logic         fb;

  always_comb begin
    fb = ^(state & TAPS);
    state_nxt = state;
    if (load) state_nxt = SEED;
    else if (adv) state_nxt = {state[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= state_nxt;
  end

  assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/sc_edge_core.sv
module sc_edge_core #(
  parameter int unsigned PIX_W = 8
) (
  input  logic [PIX_W-1:0] pix [4],
  input  logic [PIX_W-1:0] rnd,
  input  logic             sel,
  output logic             edge_bit
);
  logic [3:0] sbit;
  logic       diff_main;
  logic       diff_anti;

  for (genvar g = 0; g < 4; g++) begin : g_cmp
    assign sbit[g] = pix[g] > rnd;
  end

  // index order: 0 tl, 1 tr, 2 bl, 3 br
  assign diff_main = sbit[0] ^ sbit[3];
  assign diff_anti = sbit[1] ^ sbit[2];
  assign edge_bit  = sel ? diff_anti : diff_main;

  always_comb begin
    if (pix[0] == pix[3] && pix[1] == pix[2])
      assert_eq_diag_zero_R2: assert (edge_bit == 1'b0);
  end
endmodule

// File: rtl/sc_edge_accum.sv
module sc_edge_accum #(
  parameter int unsigned LEN_LOG   = 8,
  parameter int unsigned SNAP0_LOG = 2,
  parameter int unsigned SNAP1_LOG = 5,
  localparam int unsigned CNT_W    = LEN_LOG + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             edge_bit,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] count,
  output logic             snap_valid,
  output logic [1:0]       snap_tag,
  output logic [CNT_W-1:0] snap_value
);
  import sc_edge_pkg::*;

  localparam logic [CNT_W-1:0] RUN_LEN  = CNT_W'(1) << LEN_LOG;
  localparam logic [CNT_W-1:0] SNAP0_AT = CNT_W'(1) << SNAP0_LOG;
  localparam logic [CNT_W-1:0] SNAP1_AT = CNT_W'(1) << SNAP1_LOG;

  logic [CNT_W-1:0] cyc, cyc_nxt, count_nxt, snap_value_nxt;
  logic             busy_nxt, done_nxt, snap_valid_nxt;
  logic [1:0]       snap_tag_nxt;

  always_comb begin
    cyc_nxt        = cyc;
    count_nxt      = count;
    busy_nxt       = busy;
    done_nxt       = done;
    snap_valid_nxt = 1'b0;
    snap_tag_nxt   = snap_tag;
    snap_value_nxt = snap_value;
    if (start) begin
      cyc_nxt   = '0;
      count_nxt = '0;
      busy_nxt  = 1'b1;
      done_nxt  = 1'b0;
    end else if (busy) begin
      count_nxt = count + {{(CNT_W-1){1'b0}}, edge_bit};
      cyc_nxt   = cyc + 1'b1;
      if (cyc_nxt == SNAP0_AT) begin
        snap_valid_nxt = 1'b1;
        snap_tag_nxt   = SNAP_EARLY;
        snap_value_nxt = count_nxt << (LEN_LOG - SNAP0_LOG);
      end
      if (cyc_nxt == SNAP1_AT) begin
        snap_valid_nxt = 1'b1;
        snap_tag_nxt   = SNAP_MID;
        snap_value_nxt = count_nxt << (LEN_LOG - SNAP1_LOG);
      end
      if (cyc_nxt == RUN_LEN) begin
        snap_valid_nxt = 1'b1;
        snap_tag_nxt   = SNAP_FINAL;
        snap_value_nxt = count_nxt;
        busy_nxt       = 1'b0;
        done_nxt       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc        <= '0;
      count      <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      snap_valid <= 1'b0;
      snap_tag   <= SNAP_EARLY;
      snap_value <= '0;
    end else begin
      cyc        <= cyc_nxt;
      count      <= count_nxt;
      busy       <= busy_nxt;
      done       <= done_nxt;
      snap_valid <= snap_valid_nxt;
      snap_tag   <= snap_tag_nxt;
      snap_value <= snap_value_nxt;
    end
  end

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (count == $past(count) || count == $past(count) + 1'b1));
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cyc);
  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(count)));
endmodule

// File: rtl/sc_edge_window.sv
module sc_edge_window #(
  parameter int unsigned PIX_W     = 8,
  parameter int unsigned SNAP0_LOG = 2,
  parameter int unsigned SNAP1_LOG = 5,
  localparam int unsigned CNT_W    = PIX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PIX_W-1:0] pix_tl,
  input  logic [PIX_W-1:0] pix_tr,
  input  logic [PIX_W-1:0] pix_bl,
  input  logic [PIX_W-1:0] pix_br,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] count,
  output logic             snap_valid,
  output logic [1:0]       snap_tag,
  output logic [CNT_W-1:0] snap_value
);
  import sc_edge_pkg::*;

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [PIX_W-1:0] rnd_state, sel_state;
  logic [PIX_W-1:0] pix_vec [4];
  logic             edge_bit;
  logic             gen_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign pix_vec[0] = pix_tl;
  assign pix_vec[1] = pix_tr;
  assign pix_vec[2] = pix_bl;
  assign pix_vec[3] = pix_br;
  assign gen_adv    = busy & ~start;

  sc_lfsr #(.W(PIX_W), .TAPS(PIX_W'(RND_TAPS)), .SEED(PIX_W'(RND_SEED))) u_rnd (
    .clk(clk), .rst_n(rst_int_n), .load(start), .adv(gen_adv), .state(rnd_state));

  sc_lfsr #(.W(PIX_W), .TAPS(PIX_W'(SEL_TAPS)), .SEED(PIX_W'(SEL_SEED))) u_sel (
    .clk(clk), .rst_n(rst_int_n), .load(start), .adv(gen_adv), .state(sel_state));

  sc_edge_core #(.PIX_W(PIX_W)) u_core (
    .pix(pix_vec), .rnd(rnd_state), .sel(sel_state[PIX_W-1]), .edge_bit(edge_bit));

  sc_edge_accum #(.LEN_LOG(PIX_W), .SNAP0_LOG(SNAP0_LOG), .SNAP1_LOG(SNAP1_LOG)) u_acc (
    .clk(clk), .rst_n(rst_int_n), .start(start), .edge_bit(edge_bit),
    .busy(busy), .done(done), .count(count), .snap_valid(snap_valid),
    .snap_tag(snap_tag), .snap_value(snap_value));
endmodule

// File: tb/sc_edge_window_bench.sv
module sc_edge_window_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] pix_tl = '0, pix_tr = '0, pix_bl = '0, pix_br = '0;
  logic       busy, done, snap_valid;
  logic [8:0] count, snap_value;
  logic [1:0] snap_tag;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sc_edge_window u_sc_edge_window (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pix_tl(pix_tl), .pix_tr(pix_tr), .pix_bl(pix_bl), .pix_br(pix_br),
    .busy(busy), .done(done), .count(count), .snap_valid(snap_valid),
    .snap_tag(snap_tag), .snap_value(snap_value));

  // {tl, tr, bl, br}
  localparam logic [31:0] VECS [6] = '{
    {8'd128, 8'd128, 8'd128, 8'd128},
    {8'd200, 8'd50,  8'd50,  8'd200},
    {8'd255, 8'd0,   8'd0,   8'd0},
    {8'd255, 8'd255, 8'd0,   8'd0},
    {8'd0,   8'd255, 8'd255, 8'd0},
    {8'd180, 8'd40,  8'd90,  8'd20}
  };

  int exp_cum [257];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model from R2 R3 R4: shared random compare, XOR diagonals, select on bit 7
  task automatic build_model(input logic [31:0] v);
    logic [7:0] rp, rs, tl, tr, bl, br;
    logic d1, d2, o;
    rp = 8'h01; rs = 8'hA5;
    {tl, tr, bl, br} = v;
    exp_cum[0] = 0;
    for (int i = 1; i <= 256; i++) begin
      d1 = (tl > rp) ^ (br > rp);
      d2 = (tr > rp) ^ (bl > rp);
      o  = rs[7] ? d2 : d1;
      exp_cum[i] = exp_cum[i-1] + int'(o);
      rp = {rp[6:0], rp[7] ^ rp[5] ^ rp[4] ^ rp[3]};
      rs = {rs[6:0], rs[7] ^ rs[5] ^ rs[4] ^ rs[2]};
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_and_check(input logic [31:0] v, input bit do_start);
    {pix_tl, pix_tr, pix_bl, pix_br} = v;
    build_model(v);
    if (do_start) pulse_start();
    for (int i = 1; i <= 256; i++) begin
      @(posedge clk); @(negedge clk);
      check("R6 count per cycle (R3 R4 model)", int'(count), exp_cum[i]);
      if (i == 4) begin
        check("R9 snap4 valid", int'(snap_valid), 1);
        check("R9 snap4 tag", int'(snap_tag), 0);
        check("R9 snap4 value", int'(snap_value), exp_cum[4] * 64);
      end else if (i == 32) begin
        check("R9 snap32 valid", int'(snap_valid), 1);
        check("R9 snap32 tag", int'(snap_tag), 1);
        check("R9 snap32 value", int'(snap_value), exp_cum[32] * 8);
      end else if (i == 256) begin
        check("R9 snap256 valid", int'(snap_valid), 1);
        check("R9 snap256 tag", int'(snap_tag), 2);
        check("R9 snap256 value", int'(snap_value), exp_cum[256]);
        check("R7 busy low at end", int'(busy), 0);
        check("R7 done high at end", int'(done), 1);
      end else begin
        check("R9 no stray snap", int'(snap_valid), 0);
        check("R7 busy during run", int'(busy), 1);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 count in reset", int'(count), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 snap_valid after reset", int'(snap_valid), 0);

    for (int k = 0; k < 6; k++) run_and_check(VECS[k], 1'b1);

    // R2: equal diagonals give zero, R11: full diagonal contrast gives 255
    {pix_tl, pix_tr, pix_bl, pix_br} = VECS[1];
    pulse_start();
    repeat (260) @(negedge clk);
    check("R2 equal diagonals final", int'(count), 0);
    {pix_tl, pix_tr, pix_bl, pix_br} = VECS[3];
    pulse_start();
    repeat (260) @(negedge clk);
    check("R11 full contrast final", int'(count), 255);

    // R8: done and count hold
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R8 count held", int'(count), 255);
      check("R8 done held", int'(done), 1);
    end

    // R10: restart in mid-run
    {pix_tl, pix_tr, pix_bl, pix_br} = VECS[5];
    pulse_start();
    repeat (10) @(negedge clk);
    check("R10 busy mid-run", int'(busy), 1);
    pulse_start();
    check("R10 count cleared on restart", int'(count), 0);
    run_and_check(VECS[5], 1'b0);

    // R1: reset in mid-run
    pulse_start();
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 busy on mid-run reset", int'(busy), 0);
    check("R1 count on mid-run reset", int'(count), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 done after mid-run reset", int'(done), 0);
    // R5 is covered by the generator assertion over every run above

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule